// File: doc/BRIEF.md
# SMBus PEC-Validated Command Receiver

This block sits behind a byte-level SMBus/PMBus target front end. The front end reports bus events as single-cycle markers: a start condition, a stop condition, a byte received from the host, and a byte the target has sent. A level input says whether a byte is still being shifted in. The block runs a CRC-8 (generator 0x07) over every byte of a transaction. The CRC includes the address bytes on both sides of a repeated start and the bytes the target transmits itself.

For a write, the last byte before the stop is taken as the packet error code. The command is released on an execute strobe only when that byte brings the CRC residue to zero. A mismatch raises a PEC-error strobe, which the surrounding logic treats as an alert condition. For a read, the running CRC is offered as the byte to append after the final data byte. A quiet-bus timer forces the receiver back to idle after a parameterised number of silent cycles.

The controller has five states. IDLE waits for a start. ADDR takes the address byte. WRITE collects the command, data and PEC. READ follows the bytes the target transmits. DROP holds a discarded transaction until its stop arrives.

The transitions are:
- IDLE→ADDR on a start.
- ADDR→WRITE on an address with bit 0 = 0, when no write bytes have been collected yet.
- ADDR→DROP on an address with bit 0 = 0, when write bytes have already been collected.
- ADDR→READ on an address with bit 0 = 1.
- ADDR→IDLE on a stop.
- WRITE→ADDR on a repeated start.
- WRITE→DROP on overflow.
- WRITE→IDLE on a stop.
- READ→ADDR on a repeated start.
- READ→IDLE on a stop.
- DROP→IDLE on a stop.
- Any state→IDLE on a re-initialisation pulse.

Top module: `pec_cmd_rx`

## Requirements
- R1: After reset, exec_stb, pec_fail, reinit and pec_out_vld are all 0.
- R2: The CRC is CRC-8, polynomial 0x07, processed MSB first, and preset to 0x00 by a start seen in IDLE. A write must consist of address (bit 0 = 0), command, 0..MAX_DATA data bytes and a PEC byte, followed by a stop. When the CRC of all these bytes, the PEC included, is 0x00, exec_stb pulses for one cycle in the cycle after the stop. With it, exec_cmd carries the command, exec_len the data count, and exec_data holds data byte i at bits [8i+7:8i].
- R3: In a write of at least command plus one more byte whose residue is not 0x00, pec_fail pulses for one cycle after the stop, and exec_stb stays 0.
- R4: A write holding only the address and command (no PEC byte) produces neither exec_stb nor pec_fail.
- R5: A start seen outside IDLE is a repeated start and leaves the CRC unchanged. While in READ, pec_out_vld is 1 and pec_out equals the CRC of every byte since the start: both address bytes, the command and each transmitted byte.
- R6: A transaction that entered READ never produces exec_stb or pec_fail at its stop.
- R7: A stop that arrives while bit_busy is 1 discards the transaction with no exec_stb and no pec_fail.
- R8: A write with more than MAX_DATA data bytes is discarded at its stop with no exec_stb and no pec_fail.
- R9: After TIMEOUT_CYC clock cycles with no start, stop, rx_valid or tx_done, reinit pulses for one cycle. It pulses once per quiet spell, and the receiver returns to IDLE, so the rest of an interrupted write is not executed.
- R10: Events presented in the cycle in which reinit is 1 are ignored, including a start.
- R11: A stop seen directly after a start, before any address byte, produces neither exec_stb nor pec_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated-start marker |
| bus_stop | input | 1 | Stop marker |
| bit_busy | input | 1 | A byte is partly shifted in |
| rx_valid | input | 1 | Host-sent byte available |
| rx_byte | input | 8 | Host-sent byte |
| tx_done | input | 1 | Target finished sending a byte |
| tx_byte | input | 8 | Byte the target sent |
| exec_stb | output | 1 | Validated write command strobe |
| exec_cmd | output | 8 | Command code |
| exec_data | output | MAX_DATA*8 | Data bytes, byte 0 lowest |
| exec_len | output | $clog2(MAX_DATA+1) | Number of data bytes |
| pec_fail | output | 1 | PEC mismatch strobe |
| pec_out | output | 8 | PEC byte to append on reads |
| pec_out_vld | output | 1 | pec_out is meaningful (READ state) |
| reinit | output | 1 | Quiet-bus re-initialisation pulse |

## Verification
The bench builds the block with MAX_DATA = 3 and TIMEOUT_CYC = 40. The small buffer puts every legal data length, and the first overflow length, within a short sweep. For each of those lengths the bench steps through a spread of command codes with a good PEC and with a PEC carrying a single flipped bit. Reads are swept over one to four transmitted bytes. The short timeout allows the quiet-bus pulse to be timed to the exact cycle, with an event placed inside the pulse cycle.

// File: rtl/pec_rx_pkg.sv
package pec_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_DROP
    } rx_state_t;

    localparam logic [7:0] PEC_POLY = 8'h07;
endpackage

// File: rtl/crc8_byte.sv
module crc8_byte
    import pec_rx_pkg::*;
(
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    logic [7:0] stage [0:8];

    assign stage[0] = crc_in ^ data_in;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = stage[b][7] ? ({stage[b][6:0], 1'b0} ^ PEC_POLY)
                                        : {stage[b][6:0], 1'b0};
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/quiet_timer.sv
module quiet_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (activity) begin
                cnt_q <= '0;
            end else if (cnt_q != CW'(LIMIT)) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(LIMIT - 1)) begin
                    fire <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/payload_buf.sv
module payload_buf #(
    parameter int SLOTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(SLOTS+1)-1:0] wr_idx,
    input  logic [7:0]           wr_byte,
    output logic [SLOTS*8-1:0]   flat
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flat[s*8 +: 8] <= 8'h00;
            end else if (wr_en && wr_idx == ($clog2(SLOTS+1))'(s)) begin
                flat[s*8 +: 8] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/pec_cmd_rx.sv
module pec_cmd_rx
    import pec_rx_pkg::*;
#(
    parameter int MAX_DATA    = 4,
    parameter int TIMEOUT_CYC = 50_000_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_start,
    input  logic                          bus_stop,
    input  logic                          bit_busy,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_byte,
    input  logic                          tx_done,
    input  logic [7:0]                    tx_byte,
    output logic                          exec_stb,
    output logic [7:0]                    exec_cmd,
    output logic [MAX_DATA*8-1:0]         exec_data,
    output logic [$clog2(MAX_DATA+1)-1:0] exec_len,
    output logic                          pec_fail,
    output logic [7:0]                    pec_out,
    output logic                          pec_out_vld,
    output logic                          reinit
);
    localparam int SLOTS = MAX_DATA + 2;
    localparam int IW    = $clog2(SLOTS + 1);
    localparam int LW    = $clog2(MAX_DATA + 1);

    rx_state_t         state, state_nx;
    logic [7:0]        crc_q, crc_nx, feed_byte;
    logic [IW-1:0]     wcnt_q;
    logic [SLOTS*8-1:0] buf_flat;
    logic              activity, buf_we;

    assign activity  = bus_start | bus_stop | rx_valid | tx_done;
    assign feed_byte = rx_valid ? rx_byte : tx_byte;

    crc8_byte u_crc (
        .crc_in  (crc_q),
        .data_in (feed_byte),
        .crc_out (crc_nx)
    );

    quiet_timer #(.LIMIT(TIMEOUT_CYC)) u_quiet (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (activity),
        .fire     (reinit)
    );

    assign buf_we = (state == ST_WRITE) && rx_valid && !bus_stop && !bus_start
                    && !reinit && (wcnt_q != IW'(SLOTS));

    payload_buf #(.SLOTS(SLOTS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (wcnt_q),
        .wr_byte (rx_byte),
        .flat    (buf_flat)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (reinit) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (bus_start) state_nx = ST_ADDR;
                end
                ST_ADDR: begin
                    if (bus_stop) begin
                        state_nx = ST_IDLE;
                    end else if (rx_valid) begin
                        if (rx_byte[0])          state_nx = ST_READ;
                        else if (wcnt_q == '0)   state_nx = ST_WRITE;
                        else                     state_nx = ST_DROP;
                    end
                end
                ST_WRITE: begin
                    if (bus_stop)                                 state_nx = ST_IDLE;
                    else if (bus_start)                           state_nx = ST_ADDR;
                    else if (rx_valid && wcnt_q == IW'(SLOTS))    state_nx = ST_DROP;
                end
                ST_READ: begin
                    if (bus_stop)       state_nx = ST_IDLE;
                    else if (bus_start) state_nx = ST_ADDR;
                end
                ST_DROP: begin
                    if (bus_stop) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= 8'h00;
            wcnt_q    <= '0;
            exec_stb  <= 1'b0;
            exec_cmd  <= 8'h00;
            exec_data <= '0;
            exec_len  <= '0;
            pec_fail  <= 1'b0;
        end else begin
            exec_stb <= 1'b0;
            pec_fail <= 1'b0;
            if (reinit) begin
                wcnt_q <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (bus_start) begin
                            crc_q  <= 8'h00;
                            wcnt_q <= '0;
                        end
                    end
                    ST_ADDR: begin
                        if (rx_valid && !bus_stop) crc_q <= crc_nx;
                    end
                    ST_WRITE: begin
                        if (bus_stop) begin
                            if (!bit_busy && wcnt_q >= IW'(2)) begin
                                if (crc_q == 8'h00) begin
                                    exec_stb  <= 1'b1;
                                    exec_cmd  <= buf_flat[7:0];
                                    exec_data <= buf_flat[8 +: MAX_DATA*8];
                                    exec_len  <= LW'(wcnt_q - IW'(2));
                                end else begin
                                    pec_fail <= 1'b1;
                                end
                            end
                        end else if (rx_valid && !bus_start) begin
                            crc_q <= crc_nx;
                            if (wcnt_q != IW'(SLOTS)) wcnt_q <= wcnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (tx_done && !bus_stop && !bus_start) crc_q <= crc_nx;
                    end
                    ST_DROP: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign pec_out     = crc_q;
    assign pec_out_vld = (state == ST_READ);
endmodule

// File: rtl/pec_cmd_rx_chk.sv
module pec_cmd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_start,
    input logic bus_stop,
    input logic bit_busy,
    input logic rx_valid,
    input logic tx_done,
    input logic exec_stb,
    input logic pec_fail,
    input logic pec_out_vld,
    input logic reinit
);
    assert_exec_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> $past(bus_stop));

    assert_exec_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb);

    assert_fail_excludes_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_stb && pec_fail));

    assert_read_no_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_out_vld && bus_stop) |=> (!exec_stb && !pec_fail));

    assert_busy_stop_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && bit_busy) |=> (!exec_stb && !pec_fail));

    assert_reinit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    assert_reinit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> !$past(bus_start || bus_stop || rx_valid || tx_done));

    assert_reinit_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !pec_out_vld);
endmodule

bind pec_cmd_rx pec_cmd_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .bit_busy    (bit_busy),
    .rx_valid    (rx_valid),
    .tx_done     (tx_done),
    .exec_stb    (exec_stb),
    .pec_fail    (pec_fail),
    .pec_out_vld (pec_out_vld),
    .reinit      (reinit)
);

// File: tb/pec_cmd_rx_bench.sv
`timescale 1ns/1ps
module pec_cmd_rx_bench;
    localparam int MD = 3;
    localparam int TO = 40;
    localparam int LW = $clog2(MD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_start = 0, bus_stop = 0, bit_busy = 0, rx_valid = 0, tx_done = 0;
    logic [7:0] rx_byte = 0, tx_byte = 0;
    logic exec_stb, pec_fail, pec_out_vld, reinit;
    logic [7:0] exec_cmd, pec_out;
    logic [MD*8-1:0] exec_data;
    logic [LW-1:0] exec_len;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pec_cmd_rx #(.MAX_DATA(MD), .TIMEOUT_CYC(TO)) u_pec_cmd_rx (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bit_busy(bit_busy), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_done(tx_done), .tx_byte(tx_byte), .exec_stb(exec_stb),
        .exec_cmd(exec_cmd), .exec_data(exec_data), .exec_len(exec_len),
        .pec_fail(pec_fail), .pec_out(pec_out), .pec_out_vld(pec_out_vld),
        .reinit(reinit)
    );

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] dbyte(input int cmd, input int i, input int len);
        return 8'((cmd * 7 + i * 29 + len * 3 + 1) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic ev_byte(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic ev_tx(input logic [7:0] b);
        @(negedge clk) begin tx_done = 1'b1; tx_byte = b; end
        @(negedge clk) tx_done = 1'b0;
    endtask

    task automatic ev_stop(input logic busy);
        @(negedge clk) begin bus_stop = 1'b1; bit_busy = busy; end
        @(negedge clk) begin bus_stop = 1'b0; bit_busy = 1'b0; end
    endtask

    // mode 0: correct PEC, 1: PEC with one bit flipped
    task automatic do_write(input int cmd, input int len, input int mode,
                            input logic busy, input string req);
        logic [7:0] c;
        logic [7:0] pec;
        bit expect_exec, expect_fail;
        c = crc_step(8'h00, 8'hB4);
        ev_start();
        ev_byte(8'hB4);
        c = crc_step(c, 8'(cmd));
        ev_byte(8'(cmd));
        for (int i = 0; i < len; i++) begin
            c = crc_step(c, dbyte(cmd, i, len));
            ev_byte(dbyte(cmd, i, len));
        end
        pec = (mode == 0) ? c : (c ^ (8'h01 << ((cmd + len) % 8)));
        ev_byte(pec);
        ev_stop(busy);
        expect_exec = (mode == 0) && !busy && (len <= MD);
        expect_fail = (mode == 1) && !busy && (len <= MD);
        check({req, " exec_stb"}, 32'(exec_stb), 32'(expect_exec));
        check({req, " pec_fail"}, 32'(pec_fail), 32'(expect_fail));
        if (expect_exec) begin
            check({req, " exec_cmd"}, 32'(exec_cmd), 32'(cmd));
            check({req, " exec_len"}, 32'(exec_len), 32'(len));
            for (int i = 0; i < len; i++)
                check({req, " exec_data"}, 32'(exec_data[i*8 +: 8]), 32'(dbyte(cmd, i, len)));
        end
        @(negedge clk);
        check({req, " strobe width"}, 32'(exec_stb | pec_fail), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] c;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 exec_stb", 32'(exec_stb), 32'd0);
        check("R1 pec_fail", 32'(pec_fail), 32'd0);
        check("R1 reinit", 32'(reinit), 32'd0);
        check("R1 pec_out_vld", 32'(pec_out_vld), 32'd0);
        rst_n = 1'b1;

        // R2 / R3 / R8: sweep commands and lengths, good and corrupted PEC
        for (int cmd = 0; cmd < 256; cmd += 17) begin
            for (int len = 0; len <= MD + 1; len++) begin
                if (len <= MD) begin
                    do_write(cmd, len, 0, 1'b0, "R2");
                    do_write(cmd, len, 1, 1'b0, "R3");
                end else begin
                    do_write(cmd, len, 0, 1'b0, "R8");
                end
            end
        end

        // R7 stop while a byte is partly shifted
        do_write(8'h21, 2, 0, 1'b1, "R7");

        // R4 no PEC byte
        ev_start(); ev_byte(8'hB4); ev_byte(8'h03); ev_stop(1'b0);
        check("R4 exec_stb", 32'(exec_stb), 32'd0);
        check("R4 pec_fail", 32'(pec_fail), 32'd0);

        // R11 stop right after start
        ev_start(); ev_stop(1'b0);
        check("R11 exec_stb", 32'(exec_stb), 32'd0);
        check("R11 pec_fail", 32'(pec_fail), 32'd0);

        // R5 / R6 reads with repeated start
        for (int n = 1; n <= 4; n++) begin
            for (int cmd = 5; cmd < 256; cmd += 50) begin
                c = crc_step(8'h00, 8'hB4);
                ev_start(); ev_byte(8'hB4);
                c = crc_step(c, 8'(cmd)); ev_byte(8'(cmd));
                ev_start();
                c = crc_step(c, 8'hB5); ev_byte(8'hB5);
                for (int i = 0; i < n; i++) begin
                    c = crc_step(c, dbyte(cmd, i, n));
                    ev_tx(dbyte(cmd, i, n));
                end
                check("R5 pec_out_vld", 32'(pec_out_vld), 32'd1);
                check("R5 pec_out", 32'(pec_out), 32'(c));
                ev_stop(1'b0);
                check("R6 exec_stb", 32'(exec_stb), 32'd0);
                check("R6 pec_fail", 32'(pec_fail), 32'd0);
                check("R6 back to idle", 32'(pec_out_vld), 32'd0);
            end
        end

        // R9 / R10 quiet bus in the middle of a write
        c = crc_step(8'h00, 8'hB4);
        ev_start(); ev_byte(8'hB4);
        c = crc_step(c, 8'h44); ev_byte(8'h44);
        repeat (TO - 1) @(negedge clk);
        check("R9 no early reinit", 32'(reinit), 32'd0);
        @(negedge clk);
        check("R9 reinit pulse", 32'(reinit), 32'd1);
        bus_start = 1'b1;               // presented during the reinit cycle
        @(negedge clk) bus_start = 1'b0;
        check("R9 reinit single", 32'(reinit), 32'd0);
        ev_byte(8'hB4); ev_byte(8'h44);
        ev_byte(crc_step(crc_step(8'h00, 8'hB4), 8'h44));
        ev_stop(1'b0);
        check("R10 start ignored exec", 32'(exec_stb), 32'd0);
        check("R10 start ignored fail", 32'(pec_fail), 32'd0);

        // R9 quiet spell from idle: exactly one pulse
        repeat (TO - 1) @(negedge clk);
        check("R9 idle no early", 32'(reinit), 32'd0);
        @(negedge clk);
        check("R9 idle pulse", 32'(reinit), 32'd1);
        repeat (TO + 5) begin
            @(negedge clk);
            check("R9 one pulse per spell", 32'(reinit), 32'd0);
        end

        // R2 after recovery: a normal write still works
        do_write(8'h7E, MD, 0, 1'b0, "R2 recovery");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule